// File: doc/BRIEF.md
# Chainable Synchronous Up-Counter

This block is a synchronous binary up-counter built from identical 4-bit slices that are wired into one wide counter. Every slice has its own register. All slices are clocked by one shared rising edge. There is no ripple clocking between bits or between slices. A slice advances only when its carry-enable input is high, and that input comes from the terminal-count flag of the slice below. A chain of N slices therefore counts as one 4N-bit binary counter.

Two separate enables gate counting. The advance enable only gates the increment. The carry enable gates the increment and also qualifies the terminal-count output. An active-low parallel load is synchronous and overrides both enables. An active-low clear acts at once, without waiting for the clock, and overrides everything else.

Top module: `cnt_chain`

## Requirements
- R1: Every bit of every slice updates on the same rising clock edge. For example, the 12-bit value 0x0FF becomes 0x100 in a single edge.
- R2: While `clr_n` is low, `count_out` is 0. It goes to 0 without waiting for a clock edge, whatever the levels of `load_n`, `en_p` and `en_t`.
- R3: When `load_n` is low at a rising edge, `count_out` takes the value of `data_in`, whatever the levels of the enables.
- R4: When `load_n`, `en_p` and `en_t` are all high at a rising edge, `count_out` increases by one.
- R5: When `en_p` is low and `load_n` is high, `count_out` holds its value across the edge.
- R6: When `en_t` is low and `load_n` is high, `count_out` holds its value across the edge.
- R7: An enabled count from the all-ones value wraps `count_out` to 0.
- R8: `carry_out` is high exactly when `en_t` is high and `count_out` is all ones. It follows combinationally, and `en_p` has no effect on it.
- R9: Slice k advances only on an edge where the carry enable reaching it is high. That enable is `en_t` ANDed with the all-ones flags of slices 0..k-1. Each slice passes on its terminal flag, so the chain behaves as one 4N-bit counter.
- R10: The priority order is clear first, then load, then count, then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock |
| clr_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_p | input | 1 | Advance enable (gates counting only) |
| en_t | input | 1 | Carry enable (gates counting and carry_out) |
| data_in | input | 4*STAGES | Parallel load value |
| count_out | output | 4*STAGES | Current count, slice 0 in the low bits |
| carry_out | output | 1 | Terminal-count flag of the whole chain |

## Verification
The functions that collide are load and count: with both enables high and `load_n` low on the same edge, the load must win. The bench provokes this deliberately, and again through the random stretch. The clear also lands between two edges while `load_n` is low and both enables are high, and the bench checks at the falling edge that the count is already zero, before any rising edge could act. A behavioural 12-bit model compares `count_out` and `carry_out` on every clock. Enables are toggled at the all-ones value to separate the carry gating of `en_t` from that of `en_p`.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int STAGE_W   = 4;
    localparam int CHAIN_LEN = 3;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic carry_en;
    } stage_ctl_t;

    localparam logic [STAGE_W-1:0] SLICE_ONES = '1;
    localparam logic [STAGE_W-1:0] SLICE_STEP = STAGE_W'(1);

    function automatic logic is_terminal(input logic [STAGE_W-1:0] v);
        return v == SLICE_ONES;
    endfunction

    function automatic logic [STAGE_W-1:0] next_value(
        input op_e                op,
        input logic [STAGE_W-1:0] cur,
        input logic [STAGE_W-1:0] din
    );
        logic [STAGE_W-1:0] r;
        case (op)
            OP_LOAD:  r = din;
            OP_COUNT: r = cur + SLICE_STEP;
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cnt_pkg::*;
(
    input  logic       load_n,
    input  logic       en_p,
    input  logic       en_t,
    output stage_ctl_t ctl
);

    always_comb begin
        ctl.carry_en = en_t;
        if (!load_n)
            ctl.op = OP_LOAD;
        else if (en_p && en_t)
            ctl.op = OP_COUNT;
        else
            ctl.op = OP_HOLD;
    end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [STAGE_W-1:0] d,
    output logic [STAGE_W-1:0] q,
    output logic               rco
);

    stage_ctl_t ctl;

    cnt_op_decode u_dec (
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .ctl    (ctl)
    );

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else
            q <= next_value(ctl.op, q, d);
    end

    assign rco = ctl.carry_en && is_terminal(q);

    // R2: the register sits at zero at any edge where the clear is held low
    assert_clear_R2: assert property (@(posedge clk) !clr_n |-> q == '0);

    // R3 / R10: a load takes the data whatever the enables are
    assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(d));

    // R4: both enables high with no load gives one step
    assert_step_R4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> q == $past(q) + SLICE_STEP);

    // R5: advance enable low holds the slice
    assert_hold_p_R5: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !en_p) |=> $stable(q));

    // R6: carry enable low holds the slice
    assert_hold_t_R6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !en_t) |=> $stable(q));

    // R8: terminal flag implies carry enable
    assert_rco_gate_R8: assert property (@(posedge clk) disable iff (!clr_n)
        rco |-> en_t);

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int STAGES = CHAIN_LEN
) (
    input  logic                       clk,
    input  logic                       clr_n,
    input  logic                       load_n,
    input  logic                       en_p,
    input  logic                       en_t,
    input  logic [STAGES*STAGE_W-1:0]  data_in,
    output logic [STAGES*STAGE_W-1:0]  count_out,
    output logic                       carry_out
);

    localparam int TOTAL_W = STAGES * STAGE_W;
    localparam logic [TOTAL_W-1:0] WIDE_STEP = TOTAL_W'(1);

    logic [STAGES:0] t_link;

    assign t_link[0] = en_t;

    for (genvar i = 0; i < STAGES; i++) begin : g_slice
        cnt_stage u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (en_p),
            .en_t   (t_link[i]),
            .d      (data_in[i*STAGE_W +: STAGE_W]),
            .q      (count_out[i*STAGE_W +: STAGE_W]),
            .rco    (t_link[i+1])
        );
    end

    assign carry_out = t_link[STAGES];

    // R9 / R1: the chain as a whole steps by one across every slice
    assert_chain_step_R9: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> count_out == $past(count_out) + WIDE_STEP);

    // R7: the chain wraps from all ones to zero
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && (&count_out)) |=> count_out == '0);

    // R8: chain carry implies the whole count is at its terminal value
    assert_carry_term_R8: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out |-> (&count_out));

endmodule

// File: tb/cnt_chain_tb.sv
`timescale 1ns/100ps
module cnt_chain_tb;

    localparam int N = 3;
    localparam int W = 4 * N;

    logic         clk    = 1'b0;
    logic         clr_n  = 1'b1;
    logic         load_n = 1'b1;
    logic         en_p   = 1'b0;
    logic         en_t   = 1'b0;
    logic [W-1:0] data_in = '0;
    logic [W-1:0] count_out;
    logic         carry_out;

    int    total = 0;
    int    bad   = 0;
    int    cycles = 0;
    string cur_tag = "R2";
    logic [W-1:0] ref_q;

    always #2 clk = ~clk;

    cnt_chain #(.STAGES(N)) u_dut (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .en_p      (en_p),
        .en_t      (en_t),
        .data_in   (data_in),
        .count_out (count_out),
        .carry_out (carry_out)
    );

    // behavioural reference: one flat wide counter
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n)           ref_q <= '0;
        else if (!load_n)     ref_q <= data_in;
        else if (en_p && en_t) ref_q <= ref_q + 1;
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        logic exp_c;
        exp_c = en_t && (ref_q == '1);
        chk(cur_tag, count_out, ref_q);
        chk("R8", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, exp_c});
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    task automatic drive(input logic ld_n, input logic p, input logic t, input logic [W-1:0] d);
        @(posedge clk);
        #1;
        load_n = ld_n; en_p = p; en_t = t; data_in = d;
    endtask

    initial begin
        #1 clr_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 chk("R2 reset", count_out, '0);
        clr_n = 1'b1;

        // R10 / R3: load competes with count, load wins
        cur_tag = "R10";
        drive(1'b0, 1'b1, 1'b1, 12'h0FA);
        drive(1'b1, 1'b1, 1'b1, 12'h000);
        #1 chk("R3 load over count", count_out, 12'h0FA);

        // R4 / R1 / R9: count across the slice boundary 0x0FF -> 0x100
        cur_tag = "R9";
        repeat (6) drive(1'b1, 1'b1, 1'b1, 12'h000);
        #1 chk("R1 single-edge boundary", count_out, 12'h100);
        cur_tag = "R4";
        repeat (5) drive(1'b1, 1'b1, 1'b1, 12'h000);

        // R5: advance enable low at all ones, carry still high (R8)
        cur_tag = "R5";
        drive(1'b0, 1'b0, 1'b0, 12'hFFF);
        drive(1'b1, 1'b0, 1'b1, 12'h000);
        repeat (3) drive(1'b1, 1'b0, 1'b1, 12'h000);
        #1 chk("R8 carry with en_p low", {11'd0, carry_out}, 12'd1);
        chk("R5 hold", count_out, 12'hFFF);

        // R6: carry enable low holds and kills the carry
        cur_tag = "R6";
        repeat (3) drive(1'b1, 1'b1, 1'b0, 12'h000);
        #1 chk("R6 hold", count_out, 12'hFFF);
        chk("R8 carry off with en_t low", {11'd0, carry_out}, 12'd0);

        // R7: wrap
        cur_tag = "R7";
        drive(1'b1, 1'b1, 1'b1, 12'h000);
        drive(1'b1, 1'b0, 1'b0, 12'h000);
        #1 chk("R7 wrap", count_out, 12'h000);

        // R2: clear mid-cycle while load and enables are active
        cur_tag = "R4";
        repeat (20) drive(1'b1, 1'b1, 1'b1, 12'h000);
        drive(1'b0, 1'b1, 1'b1, 12'h5A5);
        #0.5 clr_n = 1'b0;
        #0.3 chk("R2 async clear", count_out, 12'h000);
        cur_tag = "R2";
        @(posedge clk);
        #1 clr_n = 1'b1;
        load_n = 1'b1;

        // random stretch
        cur_tag = "R10";
        for (int i = 0; i < 400; i++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            drive(r[0] | r[3], r[1] | r[3], r[2] | r[3], 12'($urandom));
        end
        drive(1'b1, 1'b0, 1'b0, 12'h000);
        @(negedge clk);
        #1 finish_run();
    end

endmodule